// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a simple request port and a lower-level flash bus engine. It turns each high-level request into the right series of 16-bit write and read cycles of the common parallel-flash command set. The requests are: read a halfword, read an identifier entry, read a query entry, clear the status register, program a halfword, program a 32-bit word, and unlock-and-erase a block. The bus engine owns the pin timing. The sequencer only raises one cycle request at a time and waits for that engine to acknowledge it.

For program and erase the sequencer polls the device status until the ready bit is set. It then pulses `done`, returns the final status byte, and extracts the erase-fail, program-fail and locked-block bits. A programmable poll budget, in clock cycles, stops a device that never becomes ready from hanging the block. The sequencer also remembers whether the device was left in read-array mode, so that back-to-back data reads do not repeat the mode-switch write.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `cyc_valid`, `done`, `err_flags` and `timeout_err` are 0.
- R2: Opcode 4 programs one halfword. It writes 0x0040 at `req_addr`, then writes `req_data[15:0]` at `req_addr`, then polls.
- R3: Opcode 5 programs a 32-bit word as two halfword programs. The first writes `req_data[31:16]` at `req_addr`; the second writes `req_data[15:0]` at `req_addr`+2. Each halfword is followed by its own complete poll before the next cycle is issued.
- R4: Opcode 6 writes 0x0060, 0x00D0, 0x0020 and 0x00D0 at `req_addr`, in that order, then polls.
- R5: Opcode 0 reads a data halfword. It writes 0x00FF at `req_addr` and then reads `req_addr`. The 0x00FF write is skipped when the last command the block wrote was 0x00FF, and any other write leaves read-array mode. After reset the mode is taken as unknown, so the first data read always issues 0x00FF.
- R6: Opcode 1 (identifier) writes 0x0090 at address 0. Opcode 2 (query) writes 0x0098 at address 0. Both then read address `req_addr`<<1, and the halfword read is returned on `rd_data` with `done`.
- R7: Opcode 3 issues exactly one cycle, a write of 0x0050 at address 0, and then finishes.
- R8: A poll round is a write of 0x0070 at the operation address followed by a read of that address. A round is repeated while bit 7 of the low byte read is 0. Once bit 7 is 1, the byte is shown on `status_out`. At `done`, `err_flags` = {status[5], status[4], status[1]} for operations that polled, and 0 for the others.
- R9: If a status read returns bit 7 = 0 when at least `poll_limit` cycles have passed since polling began, the block raises `done` with `timeout_err` = 1 and issues no further cycles.
- R10: A cycle request holds `cyc_we`, `cyc_addr` and `cyc_wdata` stable until `cyc_ack`. `req_ready` is 1 only while the block is idle, and `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken on valid and ready |
| req_op | input | 3 | Opcode (0 read, 1 ident, 2 query, 3 clear status, 4 program16, 5 program32, 6 erase) |
| req_addr | input | ADDR_W | Target byte address or index |
| req_data | input | 32 | Program data |
| poll_limit | input | TMO_W | Poll budget in cycles |
| done | output | 1 | Operation finished (one cycle) |
| rd_data | output | 16 | Last halfword read |
| status_out | output | 8 | Last status byte |
| err_flags | output | 3 | {erase fail, program fail, locked} at done |
| timeout_err | output | 1 | Poll budget expired, at done |
| cyc_valid | output | 1 | Flash cycle request |
| cyc_we | output | 1 | 1 write, 0 read |
| cyc_addr | output | ADDR_W | Cycle address |
| cyc_wdata | output | 16 | Cycle write data |
| cyc_ack | input | 1 | Cycle complete (one cycle) |
| cyc_rdata | input | 16 | Read data, valid with ack |

## Verification
The assertions assume three things about the bus engine. It acknowledges only a pending request, it holds `cyc_ack` for a single cycle, and `cyc_rdata` is meaningful only with that ack. The bench's flash model meets this: it raises the ack for one cycle, after a latency of 0 to 2 cycles, and only while `cyc_valid` is high. The check that a 0x0040 command is followed by a data write to the same address assumes program data is never 0x0040 or 0x0070, and the stimulus avoids those values. The model answers status reads only after a 0x0070 write. It counts not-ready rounds from the last 0x0040 or 0x0020 write, which matches how the block issues its commands.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_IDENT   = 3'd1,
        OP_QUERY   = 3'd2,
        OP_CLRSTAT = 3'd3,
        OP_PROG16  = 3'd4,
        OP_PROG32  = 3'd5,
        OP_ERASE   = 3'd6
    } op_e;

    typedef enum logic [1:0] {K_WR, K_RD, K_POLL, K_END} kind_e;
    typedef enum logic [1:0] {A_REQ, A_REQ2, A_ZERO, A_WIDX} asel_e;
    typedef enum logic [1:0] {D_CMD, D_LO, D_HI} dsel_e;
    typedef enum logic [1:0] {S_IDLE, S_NEXT, S_CYC} state_e;

    typedef struct packed {
        kind_e       kind;
        asel_e       asel;
        dsel_e       dsel;
        logic [15:0] cmd;
    } step_t;

    localparam logic [15:0] CMD_PROGRAM   = 16'h0040;
    localparam logic [15:0] CMD_STATUS    = 16'h0070;
    localparam logic [15:0] CMD_RD_ARRAY  = 16'h00FF;
    localparam logic [15:0] CMD_IDENT     = 16'h0090;
    localparam logic [15:0] CMD_QUERY     = 16'h0098;
    localparam logic [15:0] CMD_CLR_STAT  = 16'h0050;
    localparam logic [15:0] CMD_UNLOCK    = 16'h0060;
    localparam logic [15:0] CMD_ERASE     = 16'h0020;
    localparam logic [15:0] CMD_CONFIRM   = 16'h00D0;

    localparam int STAT_READY_BIT  = 7;
    localparam int STAT_ERASE_FAIL = 5;
    localparam int STAT_PROG_FAIL  = 4;
    localparam int STAT_LOCKED     = 1;

    function automatic step_t mk(kind_e k, asel_e a, dsel_e d, logic [15:0] c);
        step_t s;
        s.kind = k;
        s.asel = a;
        s.dsel = d;
        s.cmd  = c;
        return s;
    endfunction

    function automatic logic [2:0] err_of(logic [7:0] st);
        return {st[STAT_ERASE_FAIL], st[STAT_PROG_FAIL], st[STAT_LOCKED]};
    endfunction

    // Step list of each operation, indexed by position
    function automatic step_t seq_step(op_e op, logic [2:0] idx, logic skip_ff);
        step_t      s;
        logic [2:0] i;
        s = mk(K_END, A_REQ, D_CMD, 16'h0000);
        unique case (op)
            OP_READ: begin
                i = idx + {2'b00, skip_ff};
                if (i == 3'd0)      s = mk(K_WR, A_REQ, D_CMD, CMD_RD_ARRAY);
                else if (i == 3'd1) s = mk(K_RD, A_REQ, D_CMD, 16'h0000);
            end
            OP_IDENT, OP_QUERY: begin
                if (idx == 3'd0)
                    s = mk(K_WR, A_ZERO, D_CMD, (op == OP_IDENT) ? CMD_IDENT : CMD_QUERY);
                else if (idx == 3'd1)
                    s = mk(K_RD, A_WIDX, D_CMD, 16'h0000);
            end
            OP_CLRSTAT: begin
                if (idx == 3'd0) s = mk(K_WR, A_ZERO, D_CMD, CMD_CLR_STAT);
            end
            OP_PROG16: begin
                unique case (idx)
                    3'd0: s = mk(K_WR, A_REQ, D_CMD, CMD_PROGRAM);
                    3'd1: s = mk(K_WR, A_REQ, D_LO, 16'h0000);
                    3'd2: s = mk(K_POLL, A_REQ, D_CMD, CMD_STATUS);
                    default: ;
                endcase
            end
            OP_PROG32: begin
                unique case (idx)
                    3'd0: s = mk(K_WR, A_REQ, D_CMD, CMD_PROGRAM);
                    3'd1: s = mk(K_WR, A_REQ, D_HI, 16'h0000);
                    3'd2: s = mk(K_POLL, A_REQ, D_CMD, CMD_STATUS);
                    3'd3: s = mk(K_WR, A_REQ2, D_CMD, CMD_PROGRAM);
                    3'd4: s = mk(K_WR, A_REQ2, D_LO, 16'h0000);
                    3'd5: s = mk(K_POLL, A_REQ2, D_CMD, CMD_STATUS);
                    default: ;
                endcase
            end
            OP_ERASE: begin
                unique case (idx)
                    3'd0: s = mk(K_WR, A_REQ, D_CMD, CMD_UNLOCK);
                    3'd1: s = mk(K_WR, A_REQ, D_CMD, CMD_CONFIRM);
                    3'd2: s = mk(K_WR, A_REQ, D_CMD, CMD_ERASE);
                    3'd3: s = mk(K_WR, A_REQ, D_CMD, CMD_CONFIRM);
                    3'd4: s = mk(K_POLL, A_REQ, D_CMD, CMD_STATUS);
                    default: ;
                endcase
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fcs_step_decode.sv
module fcs_step_decode
    import flash_seq_pkg::*;
(
    input  op_e        op,
    input  logic [2:0] idx,
    input  logic       skip_ff,
    output step_t      step
);
    always_comb step = seq_step(op, idx, skip_ff);
endmodule

// File: rtl/fcs_poll_timer.sv
module fcs_poll_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_data,
    input  logic [TMO_W-1:0]  poll_limit,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic [7:0]        status_out,
    output logic [2:0]        err_flags,
    output logic              timeout_err,
    output logic              cyc_valid,
    output logic              cyc_we,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [15:0]       cyc_wdata,
    input  logic              cyc_ack,
    input  logic [15:0]       cyc_rdata
);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

    state_e            state_q;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       data_q;
    logic [2:0]        idx_q;
    logic              ph_q;
    logic              skip_q;
    logic              array_q;
    logic              polled_q;
    logic [7:0]        status_q;
    logic [15:0]       rd_q;
    logic              done_q;
    logic [2:0]        err_q;
    logic              tmo_q;

    step_t             step;
    logic              tmr_run;
    logic              tmr_expired;

    fcs_step_decode u_decode (
        .op      (op_q),
        .idx     (idx_q),
        .skip_ff (skip_q),
        .step    (step)
    );

    assign tmr_run = (state_q != S_IDLE) && (step.kind == K_POLL);

    fcs_poll_timer #(.CNT_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .limit   (poll_limit),
        .expired (tmr_expired)
    );

    // Cycle request fields
    always_comb begin
        cyc_valid = (state_q == S_CYC);
        cyc_we    = (step.kind == K_WR) || (step.kind == K_POLL && !ph_q);
        unique case (step.asel)
            A_REQ2:  cyc_addr = addr_q + HALF_STEP;
            A_ZERO:  cyc_addr = '0;
            A_WIDX:  cyc_addr = addr_q << 1;
            default: cyc_addr = addr_q;
        endcase
        unique case (step.dsel)
            D_LO:    cyc_wdata = data_q[15:0];
            D_HI:    cyc_wdata = data_q[31:16];
            default: cyc_wdata = step.cmd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            op_q     <= OP_READ;
            addr_q   <= '0;
            data_q   <= '0;
            idx_q    <= '0;
            ph_q     <= 1'b0;
            skip_q   <= 1'b0;
            array_q  <= 1'b0;
            polled_q <= 1'b0;
            status_q <= '0;
            rd_q     <= '0;
            done_q   <= 1'b0;
            err_q    <= '0;
            tmo_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= '0;
            tmo_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q     <= op_e'(req_op);
                        addr_q   <= req_addr;
                        data_q   <= req_data;
                        idx_q    <= '0;
                        ph_q     <= 1'b0;
                        polled_q <= 1'b0;
                        skip_q   <= array_q && (op_e'(req_op) == OP_READ);
                        state_q  <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (step.kind == K_END) begin
                        done_q  <= 1'b1;
                        err_q   <= polled_q ? err_of(status_q) : 3'b000;
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_CYC;
                    end
                end
                S_CYC: begin
                    if (cyc_ack) begin
                        state_q <= S_NEXT;
                        unique case (step.kind)
                            K_WR: begin
                                array_q <= (step.dsel == D_CMD) && (step.cmd == CMD_RD_ARRAY);
                                idx_q   <= idx_q + 3'd1;
                            end
                            K_RD: begin
                                rd_q  <= cyc_rdata;
                                idx_q <= idx_q + 3'd1;
                            end
                            K_POLL: begin
                                if (!ph_q) begin
                                    array_q <= 1'b0;
                                    ph_q    <= 1'b1;
                                end else begin
                                    ph_q     <= 1'b0;
                                    status_q <= cyc_rdata[7:0];
                                    polled_q <= 1'b1;
                                    if (cyc_rdata[STAT_READY_BIT]) begin
                                        idx_q <= idx_q + 3'd1;
                                    end else if (tmr_expired) begin
                                        done_q  <= 1'b1;
                                        tmo_q   <= 1'b1;
                                        err_q   <= err_of(cyc_rdata[7:0]);
                                        state_q <= S_IDLE;
                                    end
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready   = (state_q == S_IDLE);
    assign done        = done_q;
    assign rd_data     = rd_q;
    assign status_out  = status_q;
    assign err_flags   = err_q;
    assign timeout_err = tmo_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              done,
    input logic [7:0]        status_out,
    input logic              timeout_err,
    input logic              cyc_valid,
    input logic              cyc_we,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [15:0]       cyc_wdata,
    input logic              cyc_ack
);
    logic              last_prog_q;
    logic [ADDR_W-1:0] last_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_prog_q <= 1'b0;
            last_addr_q <= '0;
        end else if (cyc_valid && cyc_ack && cyc_we) begin
            last_prog_q <= (cyc_wdata == 16'h0040);
            last_addr_q <= cyc_addr;
        end
    end

    assert_cyc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !cyc_ack) |=> (cyc_valid && $stable(cyc_we) && $stable(cyc_addr) && $stable(cyc_wdata)));

    assert_idle_no_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !cyc_valid);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_timeout_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> !status_out[7]);

    assert_prog_same_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_we && last_prog_q) |-> (cyc_addr == last_addr_q));
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W)) u_fcs_checker (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .done        (done),
    .status_out  (status_out),
    .timeout_err (timeout_err),
    .cyc_valid   (cyc_valid),
    .cyc_we      (cyc_we),
    .cyc_addr    (cyc_addr),
    .cyc_wdata   (cyc_wdata),
    .cyc_ack     (cyc_ack)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_data = '0;
    logic [15:0]   poll_limit = 16'd2000;
    logic          done;
    logic [15:0]   rd_data;
    logic [7:0]    status_out;
    logic [2:0]    err_flags;
    logic          timeout_err;
    logic          cyc_valid, cyc_we;
    logic [AW-1:0] cyc_addr;
    logic [15:0]   cyc_wdata;
    logic          cyc_ack = 1'b0;
    logic [15:0]   cyc_rdata = '0;

    always #5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .TMO_W(16)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .poll_limit(poll_limit), .done(done), .rd_data(rd_data),
        .status_out(status_out), .err_flags(err_flags), .timeout_err(timeout_err),
        .cyc_valid(cyc_valid), .cyc_we(cyc_we), .cyc_addr(cyc_addr),
        .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    // flash model configuration and log
    int        lat = 0, lat_cnt = 0;
    int        busy = 0, st_reads = 0;
    logic [7:0] stat_bits = 8'h00;
    logic      st_mode = 1'b0;
    logic          log_we   [64];
    logic [AW-1:0] log_addr [64];
    logic [15:0]   log_data [64];
    int            log_n = 0;
    logic          exp_we   [64];
    logic [AW-1:0] exp_addr [64];
    logic [15:0]   exp_data [64];
    int            exp_n = 0;

    logic       got_done = 1'b0;
    logic [15:0] c_rd;
    logic [7:0]  c_st;
    logic [2:0]  c_err;
    logic        c_tmo;

    function automatic logic [15:0] mem_val(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
    endfunction

    always @(negedge clk) begin
        if (cyc_ack) begin
            cyc_ack = 1'b0;
        end else if (cyc_valid && !rst) begin
            if (lat_cnt >= lat) begin
                lat_cnt = 0;
                cyc_ack = 1'b1;
                if (log_n < 64) begin
                    log_we[log_n] = cyc_we;
                    log_addr[log_n] = cyc_addr;
                    log_data[log_n] = cyc_we ? cyc_wdata : 16'h0000;
                end
                log_n++;
                if (cyc_we) begin
                    if (cyc_wdata == 16'h0070) st_mode = 1'b1;
                    else begin
                        st_mode = 1'b0;
                        if (cyc_wdata == 16'h0040 || cyc_wdata == 16'h0020) st_reads = 0;
                    end
                end else if (st_mode) begin
                    cyc_rdata = (st_reads < busy) ? 16'h0000 : {8'h00, 1'b1, stat_bits[6:0]};
                    st_reads++;
                end else begin
                    cyc_rdata = mem_val(cyc_addr);
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (done) begin
            got_done = 1'b1;
            c_rd = rd_data; c_st = status_out; c_err = err_flags; c_tmo = timeout_err;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic we, input logic [AW-1:0] a, input logic [15:0] d);
        exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_data[exp_n] = d;
        exp_n++;
    endtask

    task automatic push_poll(input logic [AW-1:0] a, input int b);
        for (int r = 0; r <= b; r++) begin
            push(1'b1, a, 16'h0070);
            push(1'b0, a, 16'h0000);
        end
    endtask

    task automatic check_log(input string req);
        logic ok;
        ok = (log_n == exp_n);
        if (ok) begin
            for (int k = 0; k < exp_n; k++) begin
                if (log_we[k] !== exp_we[k] || log_addr[k] !== exp_addr[k] ||
                    (exp_we[k] && log_data[k] !== exp_data[k])) begin
                    ok = 1'b0;
                    $display("FAIL %s entry %0d: actual %b/%h/%h expected %b/%h/%h", req, k,
                             log_we[k], log_addr[k], log_data[k], exp_we[k], exp_addr[k], exp_data[k]);
                end
            end
        end
        chk(ok, req, "cycle sequence (count)", log_n, exp_n);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [31:0] d);
        int n;
        log_n = 0; got_done = 1'b0; lat_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!got_done && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (!got_done) chk(1'b0, "R10", "done never seen (watchdog)", 0, 1);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [7:0]    sb;
        int            k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
        chk(cyc_valid === 1'b0, "R1", "cyc_valid", cyc_valid, 0);
        chk(done === 1'b0 && err_flags === 3'b000 && timeout_err === 1'b0, "R1", "done/err/tmo",
            {done, err_flags, timeout_err}, 0);

        // R5 first read after reset issues read-array command
        a = 24'h000124;
        run_op(3'd0, a, 0);
        exp_n = 0; push(1, a, 16'h00FF); push(0, a, 0);
        check_log("R5");
        chk(c_rd === mem_val(a), "R5", "read data", c_rd, mem_val(a));
        chk(c_err === 3'b000, "R8", "err on read", c_err, 0);
        // R5 consecutive reads skip the mode write
        for (int i = 0; i < 4; i++) begin
            a = 24'h010000 + AW'(i * 6);
            lat = i % 3;
            run_op(3'd0, a, 0);
            exp_n = 0; push(0, a, 0);
            check_log("R5");
            chk(c_rd === mem_val(a), "R5", "skip-mode read data", c_rd, mem_val(a));
        end

        // R6 identifier and query sweeps
        for (int i = 0; i < 4; i++) begin
            for (int q = 0; q < 2; q++) begin
                a = AW'(i * 5 + 16);
                lat = (i + q) % 3;
                run_op(q ? 3'd2 : 3'd1, a, 0);
                exp_n = 0; push(1, 0, q ? 16'h0098 : 16'h0090); push(0, a << 1, 0);
                check_log("R6");
                chk(c_rd === mem_val(a << 1), "R6", "index read data", c_rd, mem_val(a << 1));
            end
        end
        // R5 read after a different command needs the mode write again
        a = 24'h000200;
        run_op(3'd0, a, 0);
        exp_n = 0; push(1, a, 16'h00FF); push(0, a, 0);
        check_log("R5");

        // R2 / R8 halfword program sweep
        k = 0;
        for (int l = 0; l < 3; l++) begin
            for (int b = 0; b < 3; b++) begin
                for (int s = 0; s < 4; s++) begin
                    sb = (s == 0) ? 8'h00 : (s == 1) ? 8'h20 : (s == 2) ? 8'h10 : 8'h32;
                    lat = l; busy = b; stat_bits = sb;
                    a = 24'h001000 + AW'(k * 2);
                    run_op(3'd4, a, 32'h0000_1200 + 32'(k));
                    exp_n = 0; push(1, a, 16'h0040); push(1, a, 16'h1200 + 16'(k));
                    push_poll(a, b);
                    check_log("R2");
                    chk(c_st === {1'b1, sb[6:0]}, "R8", "final status", c_st, {1'b1, sb[6:0]});
                    chk(c_err === {sb[5], sb[4], sb[1]}, "R8", "err flags", c_err, {sb[5], sb[4], sb[1]});
                    chk(c_tmo === 1'b0, "R9", "no timeout", c_tmo, 0);
                    k++;
                end
            end
        end

        // R7 clear status, flags zero even after failing status
        run_op(3'd3, 24'h00ABCD, 0);
        exp_n = 0; push(1, 0, 16'h0050);
        check_log("R7");
        chk(c_err === 3'b000, "R8", "err on clear status", c_err, 0);

        // R3 32-bit program
        for (int b = 0; b < 3; b++) begin
            lat = b; busy = b; stat_bits = 8'h00;
            a = 24'h002000 + AW'(b * 4);
            run_op(3'd5, a, {16'hA100 + 16'(b), 16'h0B00 + 16'(b)});
            exp_n = 0;
            push(1, a, 16'h0040); push(1, a, 16'hA100 + 16'(b)); push_poll(a, b);
            push(1, a + 2, 16'h0040); push(1, a + 2, 16'h0B00 + 16'(b)); push_poll(a + 2, b);
            check_log("R3");
            chk(c_st === 8'h80, "R3", "final status", c_st, 8'h80);
        end

        // R4 erase
        for (int b = 0; b < 3; b++) begin
            lat = 2 - b; busy = b; stat_bits = (b == 1) ? 8'h22 : 8'h00;
            a = 24'h020000 * AW'(b + 1);
            run_op(3'd6, a, 0);
            exp_n = 0;
            push(1, a, 16'h0060); push(1, a, 16'h00D0); push(1, a, 16'h0020); push(1, a, 16'h00D0);
            push_poll(a, b);
            check_log("R4");
            chk(c_err === ((b == 1) ? 3'b101 : 3'b000), "R8", "erase err flags", c_err,
                (b == 1) ? 3'b101 : 3'b000);
        end

        // R9 timeout with a device that never becomes ready
        lat = 0; busy = 100000; poll_limit = 16'd20;
        a = 24'h003000;
        run_op(3'd4, a, 32'h0000_3456);
        chk(c_tmo === 1'b1, "R9", "timeout flag", c_tmo, 1);
        chk(c_st[7] === 1'b0, "R9", "status not ready", c_st, 0);
        chk(log_n >= 4 && log_n % 2 == 0, "R9", "poll rounds issued", log_n, 4);
        k = log_n;
        repeat (6) @(negedge clk);
        chk(log_n == k && cyc_valid === 1'b0, "R9", "no cycles after timeout", log_n, k);
        chk(req_ready === 1'b1, "R10", "idle after timeout", req_ready, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule